// File: doc/BRIEF.md
# Interlocked Request/Acknowledge Bus Transfer Pair

This block joins an initiating controller and a responding controller across a bus that carries no shared clock, so every step of a transfer is confirmed by the far side before the next one starts. Local logic asks the initiator for one transfer with a single-cycle `start` strobe, giving the direction, a word address and, for a write, the data. The initiator puts address, direction and write data on the bus. It waits a fixed number of clock cycles so that the address can decode, and only then raises its request line.

The responder owns a small word store. When it sees request, it either stores the bus data (write) or puts the addressed word on the bus (read), and in the same step it raises acknowledge. The initiator drops request once it sees acknowledge, and takes read data as it does so. The responder then drops acknowledge once request is gone. The initiator frees the bus and reports completion only after acknowledge has fallen. Both controllers run from one clock in this model. Each one passes the handshake line that it receives through a two-stage synchronizer, so the pair behaves as it would with two unrelated clocks.

Top module: `hs_bus_pair`

## Requirements
- R1: While reset is held, and just after it is released, `busy`, `done`, `bus_req` and `bus_ack` are 0, and `bus_data` reads 0 because nothing drives it.
- R2: A `start` sampled while idle makes `busy` go high on that edge. From then on `bus_addr` equals `addr` and `bus_dir` equals `wr`, and for a write `bus_data` equals `wdata`.
- R3: `bus_req` rises exactly `DECODE_CYC` clock cycles after `busy` rises.
- R4: `bus_ack` rises only while `bus_req` is high. A write stores the `bus_data` word at `bus_addr` in the responder, and a later read of that address returns it.
- R5: `bus_req` falls only after `bus_ack` has been high.
- R6: `bus_ack` falls only after `bus_req` has been low.
- R7: The responder drives `bus_data` only during a read and only while `bus_ack` is high, and it then carries the addressed word. At all other points of a read, `bus_data` is 0. The initiator never drives `bus_data` at the same time as the responder.
- R8: `bus_addr`, `bus_dir` and write data hold steady from the rise of `busy` until `bus_ack` has fallen. `done` is then high for exactly one cycle, and in that cycle `busy` is already low.
- R9: A `start` pulse that arrives while `busy` is high is ignored: no second transfer begins, and the store is left unchanged.
- R10: `wr`=1 (and `bus_dir`=1) selects a write, and `wr`=0 (and `bus_dir`=0) selects a read. After a read, `rdata` holds the word captured when `bus_req` fell, until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both controllers |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle transfer request from local logic |
| wr | input | 1 | Direction: 1 write, 0 read |
| addr | input | AW | Word address of the transfer |
| wdata | input | DW | Data for a write |
| busy | output | 1 | Initiator owns the bus and a transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of the transfer |
| rdata | output | DW | Word captured by the last read |
| bus_req | output | 1 | Request line, initiator to responder |
| bus_ack | output | 1 | Acknowledge line, responder to initiator |
| bus_dir | output | 1 | Direction on the bus, 1 write |
| bus_addr | output | AW | Address on the bus |
| bus_data | output | DW | Shared data lines, 0 when nobody drives them |

## Verification
The assertions rely on `start` being treated only as a strobe. They also rely on `addr`, `wr` and `wdata` mattering only on the cycle in which an idle initiator accepts them, and on `DECODE_CYC` being at least 1. The bench drives every input on the falling edge and holds `start` for one cycle only. It aims the one pulse that arrives during a transfer at a different address with different data, which tests that the pulse is ignored and not merely harmless. The bench watches the handshake at the ports on each falling edge and checks each edge of `bus_req` and `bus_ack` against the level of the other line one cycle earlier.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_SETUP = 2'd1,
    M_REQ   = 2'd2,
    M_REL   = 2'd3
  } ini_state_t;

  typedef enum logic {
    S_WAIT = 1'b0,
    S_ACK  = 1'b1
  } rsp_state_t;

  // Counter preload so that request rises after exactly d settle cycles.
  function automatic int unsigned settle_preload(input int unsigned d);
    return (d > 0) ? d - 1 : 0;
  endfunction

  // Width needed to count 0..n.
  function automatic int unsigned count_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic meta_q;
  logic stab_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;
endmodule

// File: rtl/hs_initiator.sv
module hs_initiator
  import hs_pkg::*;
#(
  parameter int unsigned AW         = 4,
  parameter int unsigned DW         = 8,
  parameter int unsigned DECODE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  input  logic          ack_in,
  output logic          req_out,
  output logic          dir_out,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic [DW-1:0] data_in
);
  localparam int unsigned CW = count_width(DECODE_CYC);
  localparam int unsigned AGW = count_width(DECODE_CYC + 1);

  ini_state_t    state_q;
  logic [CW-1:0] settle_q;
  logic          req_q;
  logic          dir_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;
  logic          ack_s;

  hs_sync2 u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ack_in),
    .dout (ack_s)
  );

  // Named internal events
  logic accept_ev;
  logic settle_end_ev;
  logic ack_seen_ev;
  logic ack_gone_ev;
  assign accept_ev     = (state_q == M_IDLE) && start;
  assign settle_end_ev = (state_q == M_SETUP) && (settle_q == '0);
  assign ack_seen_ev   = (state_q == M_REQ) && ack_s;
  assign ack_gone_ev   = (state_q == M_REL) && !ack_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= M_IDLE;
      settle_q <= '0;
      req_q    <= 1'b0;
      dir_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        M_IDLE: if (accept_ev) begin
          addr_q   <= addr;
          dir_q    <= wr;
          wdata_q  <= wdata;
          settle_q <= CW'(settle_preload(DECODE_CYC));
          state_q  <= M_SETUP;
        end
        M_SETUP: if (settle_end_ev) begin
          req_q   <= 1'b1;
          state_q <= M_REQ;
        end else begin
          settle_q <= settle_q - 1'b1;
        end
        M_REQ: if (ack_seen_ev) begin
          req_q <= 1'b0;
          if (!dir_q) rdata_q <= data_in;
          state_q <= M_REL;
        end
        M_REL: if (ack_gone_ev) begin
          done_q  <= 1'b1;
          state_q <= M_IDLE;
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != M_IDLE);
  assign done     = done_q;
  assign rdata    = rdata_q;
  assign req_out  = req_q;
  assign dir_out  = dir_q;
  assign addr_out = addr_q;
  assign data_out = wdata_q;
  assign data_oe  = dir_q && busy;

  // Independent age counter for the settle window check
  logic [AGW-1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= '0;
    else if (state_q != M_SETUP) age_q <= '0;
    else if (age_q != AGW'(DECODE_CYC + 1)) age_q <= age_q + 1'b1;
  end

  p_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> (age_q == AGW'(DECODE_CYC)));

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_s));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(addr_q) && $stable(dir_q) && $stable(wdata_q)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && !ack_s));

endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_pkg::*;
#(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_in,
  input  logic          dir_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          ack_out,
  output logic [DW-1:0] data_out,
  output logic          data_oe
);
  localparam int unsigned DEPTH = 1 << AW;

  rsp_state_t    state_q;
  logic          ack_q;
  logic          rd_act_q;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] store_q [DEPTH];
  logic          req_s;

  hs_sync2 u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (req_in),
    .dout (req_s)
  );

  logic take_ev;
  logic free_ev;
  assign take_ev = (state_q == S_WAIT) && req_s;
  assign free_ev = (state_q == S_ACK) && !req_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_WAIT;
      ack_q    <= 1'b0;
      rd_act_q <= 1'b0;
      rd_q     <= '0;
      for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
    end else begin
      if (take_ev) begin
        if (dir_in) store_q[addr_in] <= data_in;
        else        rd_q <= store_q[addr_in];
        rd_act_q <= !dir_in;
        ack_q    <= 1'b1;
        state_q  <= S_ACK;
      end else if (free_ev) begin
        ack_q    <= 1'b0;
        rd_act_q <= 1'b0;
        state_q  <= S_WAIT;
      end
    end
  end

  assign ack_out  = ack_q;
  assign data_out = rd_q;
  assign data_oe  = ack_q && rd_act_q;

  p_ack_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_s));

  p_ack_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> !$past(req_s));

endmodule

// File: rtl/hs_bus_pair.sv
module hs_bus_pair #(
  parameter int unsigned AW         = 4,
  parameter int unsigned DW         = 8,
  parameter int unsigned DECODE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_req,
  output logic          bus_ack,
  output logic          bus_dir,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data
);
  logic [DW-1:0] ini_dout;
  logic          ini_oe;
  logic [DW-1:0] rsp_dout;
  logic          rsp_oe;

  hs_initiator #(.AW(AW), .DW(DW), .DECODE_CYC(DECODE_CYC)) u_ini (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .busy    (busy),
    .done    (done),
    .rdata   (rdata),
    .ack_in  (bus_ack),
    .req_out (bus_req),
    .dir_out (bus_dir),
    .addr_out(bus_addr),
    .data_out(ini_dout),
    .data_oe (ini_oe),
    .data_in (bus_data)
  );

  hs_responder #(.AW(AW), .DW(DW)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_in  (bus_req),
    .dir_in  (bus_dir),
    .addr_in (bus_addr),
    .data_in (bus_data),
    .ack_out (bus_ack),
    .data_out(rsp_dout),
    .data_oe (rsp_oe)
  );

  // Wired-OR model of the shared data lines
  assign bus_data = (ini_oe ? ini_dout : '0) | (rsp_oe ? rsp_dout : '0);

  p_single_driver_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ini_oe && rsp_oe));

  p_no_back_to_back_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/tb_hs_bus_pair.sv
module tb_hs_bus_pair;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int DEC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, done, bus_req, bus_ack, bus_dir;
  logic [DW-1:0] rdata, bus_data;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hs_bus_pair #(.AW(AW), .DW(DW), .DECODE_CYC(DEC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_dir(bus_dir), .bus_addr(bus_addr), .bus_data(bus_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Handshake ordering monitor at the ports (R4, R5, R6)
  logic prev_req = 1'b0, prev_ack = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_req && bus_req) ;
      if (prev_req && !bus_req) chk(prev_ack, "R5 req fell without ack", int'(prev_ack), 1);
      if (!prev_ack && bus_ack) chk(prev_req, "R4 ack rose without req", int'(prev_req), 1);
      if (prev_ack && !bus_ack) chk(!prev_req, "R6 ack fell with req high", int'(prev_req), 0);
    end
    prev_req = bus_req;
    prev_ack = bus_ack;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // One transfer; exp_rd is the word a read must return.
  task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [DW-1:0] exp_rd, input bit poke);
    int  settle = 0;
    bit  seen_req = 0, hold_bad = 0, rd_bad = 0, got_done = 0, busy_at_done = 0;
    @(negedge clk);
    start = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int i = 0; i < 400; i++) begin
      if (poke && i == 2) begin
        start = 1'b1; wr = 1'b1; addr = a ^ 4'h6; wdata = 8'hEE;
      end else start = 1'b0;
      if (done) begin
        got_done = 1; busy_at_done = busy;
        break;
      end
      if (busy && !seen_req && !bus_req) settle++;
      if (bus_req) seen_req = 1;
      if (busy && (bus_addr != a || bus_dir != w || (w && bus_data != d))) hold_bad = 1;
      if (busy && !w) begin
        if (bus_ack && bus_data != exp_rd) rd_bad = 1;
        if (!bus_ack && bus_data != '0) rd_bad = 1;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(got_done, "R8 done reached", int'(got_done), 1);
    chk(!busy_at_done, "R8 busy low with done", int'(busy_at_done), 0);
    chk(settle == DEC, "R3 settle cycles", settle, DEC);
    chk(!hold_bad, "R2 R8 bus fields held", int'(hold_bad), 0);
    if (!w) begin
      chk(!rd_bad, "R7 read bus drive window", int'(rd_bad), 0);
      chk(rdata == exp_rd, "R10 rdata captured", int'(rdata), int'(exp_rd));
    end
    @(negedge clk);
    chk(!done, "R8 done one cycle", int'(done), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 busy/done in reset", int'({busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_req && !bus_ack, "R1 handshake idle", int'({bus_req, bus_ack}), 0);
    chk(bus_data == '0, "R1 bus undriven", int'(bus_data), 0);
  endtask

  task automatic t_write_read();
    xfer(1'b1, 4'h2, 8'hA5, 8'h00, 0);
    xfer(1'b1, 4'hF, 8'h3C, 8'h00, 0);
    xfer(1'b0, 4'h2, 8'h00, 8'hA5, 0);   // R4 stored word returned
    xfer(1'b0, 4'hF, 8'h00, 8'h3C, 0);
    xfer(1'b0, 4'h7, 8'h00, 8'h00, 0);   // never written
    chk(bus_dir == 1'b0, "R10 read direction code", int'(bus_dir), 0);
  endtask

  task automatic t_overwrite();
    xfer(1'b1, 4'h2, 8'hFF, 8'h00, 0);
    chk(bus_dir == 1'b1, "R10 write direction code", int'(bus_dir), 1);
    xfer(1'b0, 4'h2, 8'h00, 8'hFF, 0);
    xfer(1'b1, 4'h0, 8'h01, 8'h00, 0);
    xfer(1'b0, 4'h0, 8'h00, 8'h01, 0);
  endtask

  task automatic t_start_ignored();
    xfer(1'b1, 4'h5, 8'h5A, 8'h00, 0);
    xfer(1'b1, 4'h3, 8'h11, 8'h00, 1);    // poke aims at 4'h5 with 8'hEE
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req, "R9 no extra transfer", int'({busy, bus_req}), 0);
    xfer(1'b0, 4'h5, 8'h00, 8'h5A, 0);
    chk(rdata == 8'h5A, "R9 store unchanged", int'(rdata), 8'h5A);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_overwrite();
    t_start_ignored();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule